// File: doc/BRIEF.md
# Funnel Shift and Field Extract Unit

This execution unit serves a 32-bit integer pipeline. It handles four instruction forms that share one major opcode: a double-word funnel shift whose amount comes from the shift-amount register, the same funnel shift with an amount taken from the instruction, and a bit-field extract with either of those two amount sources. The issue stage presents the instruction word, the values of the two registers that the instruction names and the current shift-amount register. One cycle later the unit presents the result, the destination register index and the 3-bit condition field. A later stage uses the condition field to decide whether the next instruction is skipped. Words that fit none of the four forms are flagged as illegal.

Both sides use a valid/ready handshake. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. The unit holds one result. `in_ready` is high whenever that slot is empty or is being drained in the same cycle, so a consumer that keeps `out_ready` high sees one result per cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `fsx_unit`

## Requirements
- R1: A word is legal only if it matches one of four (value, mask) pairs. The pairs are: shift by register 0xD0000000/0xFC001FE0, shift by immediate 0xD0000800/0xFC001C00, extract by register 0xD0001000/0xFC001BE0, extract by immediate 0xD0001800/0xFC001800. Any other word gives `out_illegal`=1 with result, destination and condition all zero.
- R2: A shift takes operand B (the register named by bits 20:16) as the high word and operand A (bits 25:21) as the low word. It shifts the 64-bit pair right and returns the low 32 bits. The amount is the shift-amount register for the register form, and 31 minus bits 9:5 for the immediate form. The immediate form ignores the shift-amount register.
- R3: When bits 25:21 and 20:16 name the same register, the shift is a 32-bit rotate right of that register.
- R4: Register index 0 supplies the value zero, whatever is driven on its operand port.
- R5: Extract by register shifts operand A right by (shift-amount XOR 31), then keeps the low (32 − bits 4:0) bits.
- R6: Extract by immediate keeps (32 − bits 4:0) bits of operand A, starting at bit 31 − bits 9:5. Field bits that lie above bit 31 of the source read as zero when zero-extending.
- R7: When bit 10 is set, an extract fills the bits above the field with the field's top bit. Field bits above bit 31 of the source take the copy of source bit 31. When bit 10 is clear, the upper bits are zero.
- R8: `out_cond` is bits 15:13. `out_dst` is bits 4:0 for shifts and bits 20:16 for extracts.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs stay unchanged.
- R10: During and after reset, `out_valid` is 0, `in_ready` is 1 and all result outputs are zero.
- R11: A word accepted on an edge appears on the outputs with `out_valid`=1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 32 | Value of register named by bits 25:21 |
| in_opb | input | 32 | Value of register named by bits 20:16 |
| in_sar | input | 5 | Shift-amount register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Shift or extract result |
| out_dst | output | 5 | Destination register index |
| out_cond | output | 3 | Condition field for the later skip decision |
| out_illegal | output | 1 | Word matched none of the four forms |

## Verification
The hardest situation to reach is an extract field that runs past bit 31 of the source. In that case the fill bits must come from the shift itself and not from the field mask. The stimulus reaches it with an immediate extract that starts at bit 28 with an 8-bit length and sign extension set. A second hard case is a stalled consumer while the producer already holds the next word. The bench drops `out_ready` with a new word waiting and checks that the held result does not move. It then checks that the waiting word is taken on the first edge after release.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int W     = 32;
  localparam int AMT_W = $clog2(W);
  localparam int IDX_W = 5;
  localparam int CND_W = 3;

  localparam logic [W-1:0] PAIR_REG_VAL = 32'hD000_0000;
  localparam logic [W-1:0] PAIR_REG_MSK = 32'hFC00_1FE0;
  localparam logic [W-1:0] PAIR_IMM_VAL = 32'hD000_0800;
  localparam logic [W-1:0] PAIR_IMM_MSK = 32'hFC00_1C00;
  localparam logic [W-1:0] XTR_REG_VAL  = 32'hD000_1000;
  localparam logic [W-1:0] XTR_REG_MSK  = 32'hFC00_1BE0;
  localparam logic [W-1:0] XTR_IMM_VAL  = 32'hD000_1800;
  localparam logic [W-1:0] XTR_IMM_MSK  = 32'hFC00_1800;

  typedef enum logic [2:0] {
    K_PAIR_REG,
    K_PAIR_IMM,
    K_XTR_REG,
    K_XTR_IMM,
    K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [IDX_W-1:0]  idx_a;
    logic [IDX_W-1:0]  idx_b;
    logic [IDX_W-1:0]  dst;
    logic [CND_W-1:0]  cond;
    logic [AMT_W-1:0]  imm;
    logic [AMT_W-1:0]  clen;
    logic              sext;
  } dec_t;

  typedef struct packed {
    logic [W-1:0]      result;
    logic [IDX_W-1:0]  dst;
    logic [CND_W-1:0]  cond;
    logic              illegal;
  } res_t;
endpackage

// File: rtl/fsx_decode.sv
module fsx_decode
  import fsx_pkg::*;
(
  input  logic [W-1:0] insn,
  output dec_t         dec
);
  logic hit_pr, hit_pi, hit_xr, hit_xi;

  always_comb begin
    hit_pr = (insn & PAIR_REG_MSK) == PAIR_REG_VAL;
    hit_pi = (insn & PAIR_IMM_MSK) == PAIR_IMM_VAL;
    hit_xr = (insn & XTR_REG_MSK)  == XTR_REG_VAL;
    hit_xi = (insn & XTR_IMM_MSK)  == XTR_IMM_VAL;
  end

  always_comb begin
    dec       = '0;
    dec.kind  = K_BAD;
    dec.idx_a = insn[25:21];
    dec.idx_b = insn[20:16];
    dec.cond  = insn[15:13];
    dec.imm   = insn[9:5];
    dec.clen  = insn[4:0];
    dec.sext  = insn[10];
    if (hit_pr)      dec.kind = K_PAIR_REG;
    else if (hit_pi) dec.kind = K_PAIR_IMM;
    else if (hit_xr) dec.kind = K_XTR_REG;
    else if (hit_xi) dec.kind = K_XTR_IMM;
    // shifts write the low field, extracts the middle one
    dec.dst = (dec.kind == K_XTR_REG || dec.kind == K_XTR_IMM) ? insn[20:16]
                                                               : insn[4:0];
  end
endmodule

// File: rtl/fsx_funnel.sv
module fsx_funnel #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     hi,
  input  logic [W-1:0]     lo,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     out
);
  // low word of the 2W-bit pair after a right shift
  assign out = W'({hi, lo} >> amt);
endmodule

// File: rtl/fsx_field.sv
module fsx_field #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     shifted,
  input  logic [AMT_W-1:0] clen,
  input  logic             sext,
  output logic [W-1:0]     field
);
  logic [AMT_W-1:0] top;
  logic             fill;

  assign top  = ~clen;  // len-1 = W-1-clen
  assign fill = sext & shifted[top];

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign field[i] = (AMT_W'(i) <= top) ? shifted[i] : fill;
  end
endmodule

// File: rtl/fsx_out_stage.sv
module fsx_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  logic          vld_q;
  logic [PW-1:0] data_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/fsx_unit.sv
module fsx_unit
  import fsx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_insn,
  input  logic [W-1:0]     in_opa,
  input  logic [W-1:0]     in_opb,
  input  logic [AMT_W-1:0] in_sar,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic [IDX_W-1:0] out_dst,
  output logic [CND_W-1:0] out_cond,
  output logic             out_illegal
);
  localparam int PW = $bits(res_t);

  dec_t             dec;
  logic [W-1:0]     opa_z, opb_z, hi, sh, fld;
  logic [AMT_W-1:0] amt;
  logic             is_xtr;
  res_t             nxt, cur;
  logic [PW-1:0]    cur_bits;

  fsx_decode u_dec (.insn(in_insn), .dec(dec));

  assign opa_z  = (dec.idx_a == '0) ? '0 : in_opa;
  assign opb_z  = (dec.idx_b == '0) ? '0 : in_opb;
  assign is_xtr = (dec.kind == K_XTR_REG) || (dec.kind == K_XTR_IMM);

  always_comb begin
    unique case (dec.kind)
      K_PAIR_REG: amt = in_sar;
      K_XTR_REG:  amt = in_sar ^ AMT_W'(W-1);  // MSB-first count to shift
      default:    amt = ~dec.imm;              // W-1 minus field
    endcase
  end

  // extracts reuse the funnel: the high word is the sign or zero fill
  assign hi = is_xtr ? {W{dec.sext & opa_z[W-1]}} : opb_z;

  fsx_funnel #(.W(W), .AMT_W(AMT_W)) u_fun (
    .hi(hi), .lo(opa_z), .amt(amt), .out(sh)
  );

  fsx_field #(.W(W), .AMT_W(AMT_W)) u_fld (
    .shifted(sh), .clen(dec.clen), .sext(dec.sext), .field(fld)
  );

  always_comb begin
    nxt = '0;
    if (dec.kind == K_BAD) begin
      nxt.illegal = 1'b1;
    end else begin
      nxt.result = is_xtr ? fld : sh;
      nxt.dst    = dec.dst;
      nxt.cond   = dec.cond;
    end
  end

  fsx_out_stage #(.PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(nxt),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(cur_bits)
  );

  assign cur         = res_t'(cur_bits);
  assign out_result  = cur.result;
  assign out_dst     = cur.dst;
  assign out_cond    = cur.cond;
  assign out_illegal = cur.illegal;
endmodule

// File: rtl/fsx_unit_chk.sv
module fsx_unit_chk
  import fsx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_insn,
  input logic [W-1:0]     in_opa,
  input logic [W-1:0]     in_opb,
  input logic [AMT_W-1:0] in_sar,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic [IDX_W-1:0] out_dst,
  input logic [CND_W-1:0] out_cond,
  input logic             out_illegal
);
  function automatic logic [W-1:0] rotr(input logic [W-1:0] a,
                                        input logic [AMT_W-1:0] s);
    rotr = (a >> s) | (a << ((AMT_W+1)'(W) - {1'b0, s}));
  endfunction

  logic rot_pick;
  assign rot_pick = in_valid && in_ready && in_insn[31:26] == 6'h34 &&
                    in_insn[12:5] == 8'h00 &&
                    in_insn[25:21] == in_insn[20:16] && in_insn[20:16] != 5'd0;

  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0 && out_dst == '0 && out_cond == '0));

  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rot_pick |=> (out_result == rotr($past(in_opa), $past(in_sar))));

  assert_ready_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_dst) && $stable(out_cond) && $stable(out_illegal)));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind fsx_unit fsx_unit_chk u_chk (.*);

// File: tb/fsx_unit_bench.sv
`timescale 1ns/1ps
module fsx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_insn = '0, in_opa = '0, in_opb = '0;
  logic [4:0]  in_sar = '0;
  logic        in_ready, out_valid, out_illegal;
  logic [31:0] out_result;
  logic [4:0]  out_dst;
  logic [2:0]  out_cond;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsx_unit u_fsx_unit (.*);

  typedef struct packed {
    logic [31:0] insn; logic [31:0] opa; logic [31:0] opb; logic [4:0] sar;
    logic [31:0] res;  logic [4:0] dst;  logic [2:0] cond; logic ill;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{32'hD0410003, 32'h89ABCDEF, 32'h01234567, 5'd8,  32'h6789ABCD, 5'd3, 3'd0, 1'b0, 4'd2}, // R2
    '{32'hD0400003, 32'h89ABCDEF, 32'hFFFFFFFF, 5'd4,  32'h089ABCDE, 5'd3, 3'd0, 1'b0, 4'd4}, // R4
    '{32'hD0A50007, 32'h12345678, 32'h12345678, 5'd12, 32'h67812345, 5'd7, 3'd0, 1'b0, 4'd3}, // R3
    '{32'hD041A9E4, 32'h1234FFFF, 32'hAAAA5555, 5'd9,  32'h55551234, 5'd4, 3'd5, 1'b0, 4'd2}, // R2 R8
    '{32'hD0410BE4, 32'hCAFEF00D, 32'h11111111, 5'd3,  32'hCAFEF00D, 5'd4, 3'd0, 1'b0, 4'd2}, // R2
    '{32'hD0C91018, 32'h12345F78, 32'h0,        5'd27, 32'h000000F7, 5'd9, 3'd0, 1'b0, 4'd5}, // R5
    '{32'hD0C91418, 32'h12345F78, 32'h0,        5'd27, 32'hFFFFFFF7, 5'd9, 3'd0, 1'b0, 4'd7}, // R7
    '{32'hD0C91AF4, 32'h12ABCD56, 32'h0,        5'd0,  32'h00000BCD, 5'd9, 3'd0, 1'b0, 4'd6}, // R6
    '{32'hD0C91EF4, 32'h12ABCD56, 32'h0,        5'd0,  32'hFFFFFBCD, 5'd9, 3'd0, 1'b0, 4'd7}, // R7
    '{32'hD0C91BE0, 32'h80000001, 32'h0,        5'd0,  32'h80000001, 5'd9, 3'd0, 1'b0, 4'd6}, // R6
    '{32'hD0C91C78, 32'hA0000000, 32'h0,        5'd0,  32'hFFFFFFFA, 5'd9, 3'd0, 1'b0, 4'd7}, // R7
    '{32'hD0410023, 32'h1,        32'h2,        5'd0,  32'h0,        5'd0, 3'd0, 1'b1, 4'd1}, // R1
    '{32'hD4000000, 32'h1,        32'h2,        5'd0,  32'h0,        5'd0, 3'd0, 1'b1, 4'd1}, // R1
    '{32'hD0C91038, 32'h1,        32'h2,        5'd0,  32'h0,        5'd0, 3'd0, 1'b1, 4'd1}, // R1
    '{32'hD0091BE0, 32'hFFFFFFFF, 32'h0,        5'd0,  32'h0,        5'd9, 3'd0, 1'b0, 4'd4}, // R4
    '{32'hD0C9F018, 32'h12345F78, 32'h0,        5'd27, 32'h000000F7, 5'd9, 3'd7, 1'b0, 4'd8}  // R8
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_insn = v.insn; in_opa = v.opa; in_opb = v.opb; in_sar = v.sar;
    in_valid = 1'b1;
  endtask

  function automatic bit match(input vec_t v);
    return out_valid && out_result == v.res && out_dst == v.dst &&
           out_cond == v.cond && out_illegal == v.ill;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while held in reset
    check(!out_valid && in_ready && out_result == 0 && !out_illegal,
          "R10 reset", {out_valid, out_result[30:0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && out_dst == 0 && out_cond == 0, "R10 after reset",
          {27'd0, out_dst}, 32'h0);

    // table walk: one word per accept, result one edge later (R11)
    foreach (VECS[i]) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check(match(VECS[i]), $sformatf("R%0d vec%0d", VECS[i].req, i),
            out_result, VECS[i].res);
    end

    // R11: no new word, valid drops after the handover
    @(negedge clk);
    check(!out_valid, "R11 idle", {31'd0, out_valid}, 32'h0);

    // R9: stalled consumer with a second word waiting
    out_ready = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[4]);
    check(match(VECS[0]) && !in_ready, "R9 stall take", out_result, VECS[0].res);
    @(negedge clk);
    check(match(VECS[0]) && !in_ready, "R9 stall hold", out_result, VECS[0].res);
    @(negedge clk);
    check(match(VECS[0]), "R9 stall hold2", out_result, VECS[0].res);
    out_ready = 1'b1;
    #1;
    check(in_ready, "R9 ready on drain", {31'd0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check(match(VECS[4]), "R9 waiting word", out_result, VECS[4].res);
    @(negedge clk);
    check(!out_valid && in_ready, "R9 empty", {31'd0, out_valid}, 32'h0);

    // R10: reset mid-stream clears a held result
    out_ready = 1'b0;
    drive(VECS[2]);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && out_result == 0, "R10 reset clears", out_result, 32'h0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule